// File: doc/BRIEF.md
# Out-of-Order Issue Window with In-Order Retirement

This block is the instruction window of an out-of-order core. Decoded instructions enter a ring of numbered slots at the tail. The slot number serves as the instruction's result tag. Each slot holds an opcode, two source operands and destination information. Each operand is either a value, marked present, or the tag of the slot that will produce it.

Every cycle the window offers the oldest slot that is ready to an execution unit. A result bus returns a tag, a value and an exception cause. Operands that wait on that tag capture the value. The producing slot is marked complete.

Slots leave from the head strictly in program order, and a store is signalled to memory only when it retires. When the head slot completed with a nonzero cause, the whole window is discarded in one cycle and the cause is reported.

Top module: `rob_issue_buf`

## Requirements
- R1: After reset the window is empty: `alloc_ready_o`=1, `alloc_tag_o`=0, and `issue_valid_o`, `retire_valid_o` and `exc_valid_o` are all 0.
- R2: Accepted allocations take slots in rising circular index order, starting at the tail. `alloc_tag_o` shows the index the next entry will get. `alloc_ready_o` is 0 while DEPTH entries are held, and the full and empty cases are told apart by a wrap bit.
- R3: A slot is offered on `issue_*` only while it is occupied, has not started, and has both operands present. Once `issue_valid_o && issue_ready_i` fires for a slot, that slot is never offered again.
- R4: When several slots are ready, the one nearest the head in age order is offered, at most one per cycle. `issue_a_o`, `issue_b_o` and `issue_op_o` carry that slot's operands and opcode.
- R5: A result bus write with `wb_valid_i`=1 and tag T fills every waiting operand whose low IDX_W bits equal T: the value is stored and the operand is marked present. The consumer can be offered in the next cycle.
- R6: An entry allocated in the same cycle as a result bus write on tag T takes the bus value for any waiting operand that names T, and is stored as present.
- R7: The head slot retires in the cycle it is complete with cause 0. `retire_valid_o`, `retire_tag_o`, `retire_dst_en_o`, `retire_dst_o` and `retire_data_o` describe it. A younger complete slot never retires before the head.
- R8: `retire_store_o` is 1 only in a retire cycle whose opcode equals STORE_OP (default 4'hF). It is never 1 while the store is merely waiting or complete but not retiring.
- R9: A nonzero cause on a younger slot has no visible effect until that slot reaches the head. When the head is complete with a nonzero cause, `exc_valid_o`, `exc_cause_o` and `exc_tag_o` report it in that cycle, and `alloc_ready_o` is 0 in that cycle. In the next cycle the window is empty and the tail equals the unchanged head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | Decode presents a new entry |
| alloc_op_i | input | OP_W | Opcode of the new entry |
| alloc_a_rdy_i | input | 1 | Operand A holds a value (1) or a tag (0) |
| alloc_a_i | input | DATA_W | Operand A value or tag in the low bits |
| alloc_b_rdy_i | input | 1 | Operand B holds a value (1) or a tag (0) |
| alloc_b_i | input | DATA_W | Operand B value or tag in the low bits |
| alloc_dst_en_i | input | 1 | Entry writes an architectural register |
| alloc_dst_i | input | AREG_W | Architectural destination register |
| alloc_ready_o | output | 1 | Entry can be accepted this cycle |
| alloc_tag_o | output | IDX_W | Slot index the next entry receives |
| issue_ready_i | input | 1 | Execution unit accepts the offered slot |
| issue_valid_o | output | 1 | A ready slot is offered |
| issue_tag_o | output | IDX_W | Offered slot index |
| issue_op_o | output | OP_W | Offered opcode |
| issue_a_o | output | DATA_W | Offered operand A |
| issue_b_o | output | DATA_W | Offered operand B |
| wb_valid_i | input | 1 | Result bus write |
| wb_tag_i | input | IDX_W | Result bus tag |
| wb_data_i | input | DATA_W | Result bus value |
| wb_cause_i | input | CAUSE_W | Exception cause, 0 for none |
| retire_valid_o | output | 1 | Head slot retires this cycle |
| retire_tag_o | output | IDX_W | Retiring slot index |
| retire_dst_en_o | output | 1 | Retiring slot writes a register |
| retire_dst_o | output | AREG_W | Retiring destination register |
| retire_data_o | output | DATA_W | Retiring result value |
| retire_store_o | output | 1 | Retiring slot is a store, so memory may be written |
| exc_valid_o | output | 1 | Head exception: window flushed this cycle |
| exc_cause_o | output | CAUSE_W | Reported cause |
| exc_tag_o | output | IDX_W | Slot index of the faulting entry |

## Verification
Two situations are driven on purpose. In the first, the result bus writes a tag in the same cycle that decode allocates a consumer naming that tag. The bench then checks that the consumer is offered in the next cycle with the bus value as its operand. In the second, the head retires while a woken slot issues in the same cycle. Here the bench checks both the retire fields and the issue fields in that single cycle. A head exception is also raised while decode keeps presenting an entry, and the bench judges the result by `alloc_ready_o` being 0 in that cycle and by `alloc_tag_o` returning to the head index in the next.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        HEAD_WAIT   = 2'd0,
        HEAD_RETIRE = 2'd1,
        HEAD_FLUSH  = 2'd2
    } head_act_e;

    function automatic head_act_e head_decide(input logic used, input logic done,
                                              input logic cause_nz);
        if (!(used && done)) return HEAD_WAIT;
        if (cause_nz)        return HEAD_FLUSH;
        return HEAD_RETIRE;
    endfunction

endpackage

// File: rtl/rob_src_wake.sv
module rob_src_wake #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3
) (
    input  logic              present_i,
    input  logic [DATA_W-1:0] field_i,
    input  logic              wb_valid_i,
    input  logic [TAG_W-1:0]  wb_tag_i,
    input  logic [DATA_W-1:0] wb_data_i,
    output logic              present_o,
    output logic [DATA_W-1:0] field_o
);
    logic hit;

    always_comb begin
        hit       = !present_i && wb_valid_i && (field_i[TAG_W-1:0] == wb_tag_i);
        present_o = present_i | hit;
        field_o   = hit ? wb_data_i : field_i;
    end
endmodule

// File: rtl/rob_age_pick.sv
module rob_age_pick #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [DEPTH-1:0] req_i,
    input  logic [IDX_W-1:0] base_i,
    output logic             found_o,
    output logic [IDX_W-1:0] pick_o
);
    logic [IDX_W-1:0] idx;

    // Walk from youngest to oldest so the entry nearest the base wins.
    always_comb begin
        found_o = 1'b0;
        pick_o  = base_i;
        idx     = base_i;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            idx = base_i + IDX_W'(i);
            if (req_i[idx]) begin
                found_o = 1'b1;
                pick_o  = idx;
            end
        end
    end
endmodule

// File: rtl/rob_issue_buf.sv
module rob_issue_buf #(
    parameter int DEPTH    = 8,
    parameter int DATA_W   = 16,
    parameter int OP_W     = 4,
    parameter int AREG_W   = 5,
    parameter int CAUSE_W  = 4,
    parameter logic [OP_W-1:0] STORE_OP = '1,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int PTR_W   = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid_i,
    input  logic [OP_W-1:0]    alloc_op_i,
    input  logic               alloc_a_rdy_i,
    input  logic [DATA_W-1:0]  alloc_a_i,
    input  logic               alloc_b_rdy_i,
    input  logic [DATA_W-1:0]  alloc_b_i,
    input  logic               alloc_dst_en_i,
    input  logic [AREG_W-1:0]  alloc_dst_i,
    output logic               alloc_ready_o,
    output logic [IDX_W-1:0]   alloc_tag_o,
    input  logic               issue_ready_i,
    output logic               issue_valid_o,
    output logic [IDX_W-1:0]   issue_tag_o,
    output logic [OP_W-1:0]    issue_op_o,
    output logic [DATA_W-1:0]  issue_a_o,
    output logic [DATA_W-1:0]  issue_b_o,
    input  logic               wb_valid_i,
    input  logic [IDX_W-1:0]   wb_tag_i,
    input  logic [DATA_W-1:0]  wb_data_i,
    input  logic [CAUSE_W-1:0] wb_cause_i,
    output logic               retire_valid_o,
    output logic [IDX_W-1:0]   retire_tag_o,
    output logic               retire_dst_en_o,
    output logic [AREG_W-1:0]  retire_dst_o,
    output logic [DATA_W-1:0]  retire_data_o,
    output logic               retire_store_o,
    output logic               exc_valid_o,
    output logic [CAUSE_W-1:0] exc_cause_o,
    output logic [IDX_W-1:0]   exc_tag_o
);
    import rob_pkg::*;

    initial begin
        if ((1 << IDX_W) != DEPTH) $error("DEPTH must be a power of two");
    end

    typedef struct packed {
        logic               used;
        logic               started;
        logic               done;
        logic [OP_W-1:0]    op;
        logic               a_p;
        logic [DATA_W-1:0]  a;
        logic               b_p;
        logic [DATA_W-1:0]  b;
        logic               dst_en;
        logic [AREG_W-1:0]  dst;
        logic [DATA_W-1:0]  data;
        logic [CAUSE_W-1:0] cause;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slots;
        logic [PTR_W-1:0]  head;
        logic [PTR_W-1:0]  tail;
    } state_t;

    state_t st_q, st_d;

    logic [IDX_W-1:0] head_idx, tail_idx;
    logic             full, empty;
    head_act_e        head_act;
    logic             flush, retire_fire, alloc_fire, issue_fire;
    logic [DEPTH-1:0] ready_vec;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic [DEPTH-1:0] wa_p, wb_p;
    logic [DATA_W-1:0] wa_v [DEPTH];
    logic [DATA_W-1:0] wbv_v [DEPTH];
    logic              na_p, nb_p;
    logic [DATA_W-1:0] na_v, nb_v;
    logic [PTR_W-1:0]  occupancy;

    assign head_idx  = st_q.head[IDX_W-1:0];
    assign tail_idx  = st_q.tail[IDX_W-1:0];
    assign empty     = (st_q.head == st_q.tail);
    assign full      = (head_idx == tail_idx) && (st_q.head[IDX_W] != st_q.tail[IDX_W]);
    assign occupancy = st_q.tail - st_q.head;

    // Operand wakeup for every held slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign ready_vec[g] = st_q.slots[g].used && !st_q.slots[g].started
                              && st_q.slots[g].a_p && st_q.slots[g].b_p;
        rob_src_wake #(.DATA_W(DATA_W), .TAG_W(IDX_W)) wake_a_i (
            .present_i(st_q.slots[g].a_p), .field_i(st_q.slots[g].a),
            .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .wb_data_i(wb_data_i),
            .present_o(wa_p[g]), .field_o(wa_v[g]));
        rob_src_wake #(.DATA_W(DATA_W), .TAG_W(IDX_W)) wake_b_i (
            .present_i(st_q.slots[g].b_p), .field_i(st_q.slots[g].b),
            .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .wb_data_i(wb_data_i),
            .present_o(wb_p[g]), .field_o(wbv_v[g]));
    end

    // Same-cycle capture for the entry being allocated.
    rob_src_wake #(.DATA_W(DATA_W), .TAG_W(IDX_W)) new_a_i (
        .present_i(alloc_a_rdy_i), .field_i(alloc_a_i),
        .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .wb_data_i(wb_data_i),
        .present_o(na_p), .field_o(na_v));
    rob_src_wake #(.DATA_W(DATA_W), .TAG_W(IDX_W)) new_b_i (
        .present_i(alloc_b_rdy_i), .field_i(alloc_b_i),
        .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .wb_data_i(wb_data_i),
        .present_o(nb_p), .field_o(nb_v));

    rob_age_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) pick_i (
        .req_i(ready_vec), .base_i(head_idx),
        .found_o(pick_found), .pick_o(pick_idx));

    always_comb begin
        head_act    = head_decide(st_q.slots[head_idx].used, st_q.slots[head_idx].done,
                                  st_q.slots[head_idx].cause != '0);
        flush       = (head_act == HEAD_FLUSH);
        retire_fire = (head_act == HEAD_RETIRE);
        alloc_fire  = alloc_valid_i && !full && !flush;
        issue_fire  = pick_found && !flush && issue_ready_i;

        st_d = st_q;
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) st_d.slots[i].used = 1'b0;
            st_d.tail = st_q.head;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                st_d.slots[i].a_p = wa_p[i];
                st_d.slots[i].a   = wa_v[i];
                st_d.slots[i].b_p = wb_p[i];
                st_d.slots[i].b   = wbv_v[i];
            end
            if (wb_valid_i && st_q.slots[wb_tag_i].used) begin
                st_d.slots[wb_tag_i].done  = 1'b1;
                st_d.slots[wb_tag_i].data  = wb_data_i;
                st_d.slots[wb_tag_i].cause = wb_cause_i;
            end
            if (issue_fire) st_d.slots[pick_idx].started = 1'b1;
            if (retire_fire) begin
                st_d.slots[head_idx].used = 1'b0;
                st_d.head = st_q.head + PTR_W'(1);
            end
            if (alloc_fire) begin
                st_d.slots[tail_idx].used    = 1'b1;
                st_d.slots[tail_idx].started = 1'b0;
                st_d.slots[tail_idx].done    = 1'b0;
                st_d.slots[tail_idx].op      = alloc_op_i;
                st_d.slots[tail_idx].a_p     = na_p;
                st_d.slots[tail_idx].a       = na_v;
                st_d.slots[tail_idx].b_p     = nb_p;
                st_d.slots[tail_idx].b       = nb_v;
                st_d.slots[tail_idx].dst_en  = alloc_dst_en_i;
                st_d.slots[tail_idx].dst     = alloc_dst_i;
                st_d.slots[tail_idx].data    = '0;
                st_d.slots[tail_idx].cause   = '0;
                st_d.tail = st_q.tail + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alloc_ready_o   = !full && !flush;
    assign alloc_tag_o     = tail_idx;
    assign issue_valid_o   = pick_found && !flush;
    assign issue_tag_o     = pick_idx;
    assign issue_op_o      = st_q.slots[pick_idx].op;
    assign issue_a_o       = st_q.slots[pick_idx].a;
    assign issue_b_o       = st_q.slots[pick_idx].b;
    assign retire_valid_o  = retire_fire;
    assign retire_tag_o    = head_idx;
    assign retire_dst_en_o = st_q.slots[head_idx].dst_en;
    assign retire_dst_o    = st_q.slots[head_idx].dst;
    assign retire_data_o   = st_q.slots[head_idx].data;
    assign retire_store_o  = retire_fire && (st_q.slots[head_idx].op == STORE_OP);
    assign exc_valid_o     = flush;
    assign exc_cause_o     = st_q.slots[head_idx].cause;
    assign exc_tag_o       = head_idx;

    // Assertions
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= PTR_W'(DEPTH));

    assert_empty_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> alloc_ready_o);

    assert_single_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && issue_ready_i) |=> !(issue_valid_o && issue_tag_o == $past(issue_tag_o)));

    assert_head_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid_o |=> (st_q.head == $past(st_q.head) + PTR_W'(1)));

    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |=> (empty && $stable(st_q.head)));

    assert_no_retire_on_exc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |-> !retire_valid_o && !retire_store_o);
endmodule

// File: tb/rob_issue_buf_tb.sv
module rob_issue_buf_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid_i = 0;
    logic [3:0]  alloc_op_i = 0;
    logic        alloc_a_rdy_i = 0;
    logic [15:0] alloc_a_i = 0;
    logic        alloc_b_rdy_i = 0;
    logic [15:0] alloc_b_i = 0;
    logic        alloc_dst_en_i = 0;
    logic [4:0]  alloc_dst_i = 0;
    logic        alloc_ready_o;
    logic [2:0]  alloc_tag_o;
    logic        issue_ready_i = 0;
    logic        issue_valid_o;
    logic [2:0]  issue_tag_o;
    logic [3:0]  issue_op_o;
    logic [15:0] issue_a_o, issue_b_o;
    logic        wb_valid_i = 0;
    logic [2:0]  wb_tag_i = 0;
    logic [15:0] wb_data_i = 0;
    logic [3:0]  wb_cause_i = 0;
    logic        retire_valid_o;
    logic [2:0]  retire_tag_o;
    logic        retire_dst_en_o;
    logic [4:0]  retire_dst_o;
    logic [15:0] retire_data_o;
    logic        retire_store_o;
    logic        exc_valid_o;
    logic [3:0]  exc_cause_o;
    logic [2:0]  exc_tag_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rob_issue_buf dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_alloc(input logic [3:0] op, input logic ar, input logic [15:0] a,
                               input logic br, input logic [15:0] b,
                               input logic den, input logic [4:0] dst);
        alloc_valid_i = 1; alloc_op_i = op;
        alloc_a_rdy_i = ar; alloc_a_i = a;
        alloc_b_rdy_i = br; alloc_b_i = b;
        alloc_dst_en_i = den; alloc_dst_i = dst;
    endtask

    task automatic drive_wb(input logic [2:0] t, input logic [15:0] d, input logic [3:0] c);
        wb_valid_i = 1; wb_tag_i = t; wb_data_i = d; wb_cause_i = c;
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        check("R1 alloc_ready", alloc_ready_o, 1);
        check("R1 alloc_tag", alloc_tag_o, 0);
        check("R1 issue_valid", issue_valid_o, 0);
        check("R1 retire_valid", retire_valid_o, 0);
        check("R1 exc_valid", exc_valid_o, 0);
    endtask

    task automatic t_fill_flush();
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            drive_alloc(4'h1, 0, 16'd7, 0, 16'd7, 0, 5'd0);
            #1;
            check("R2 alloc_tag order", alloc_tag_o, k);
            check("R2 ready while room", alloc_ready_o, 1);
        end
        @(negedge clk); #1;
        check("R2 full stalls", alloc_ready_o, 0);
        check("R3 no issue without operands", issue_valid_o, 0);
        alloc_valid_i = 0;
        drive_wb(3'd0, 16'd0, 4'd3);
        @(negedge clk);
        wb_valid_i = 0;
        drive_alloc(4'h1, 1, 16'd1, 1, 16'd1, 0, 5'd0);
        #1;
        check("R9 exc_valid", exc_valid_o, 1);
        check("R9 exc_cause", exc_cause_o, 3);
        check("R9 exc_tag", exc_tag_o, 0);
        check("R9 alloc blocked in flush", alloc_ready_o, 0);
        check("R9 no retire", retire_valid_o, 0);
        @(negedge clk);
        alloc_valid_i = 0;
        #1;
        check("R9 empty after flush", alloc_ready_o, 1);
        check("R9 tail back at head", alloc_tag_o, 0);
        check("R9 nothing to issue", issue_valid_o, 0);
        check("R9 exc cleared", exc_valid_o, 0);
    endtask

    task automatic t_order();
        @(negedge clk); drive_alloc(4'h1, 1, 16'd10, 1, 16'd20, 1, 5'd3);
        @(negedge clk); drive_alloc(4'h2, 0, 16'd0, 1, 16'd7, 1, 5'd4);
        @(negedge clk); drive_alloc(4'h3, 1, 16'd1, 1, 16'd2, 0, 5'd0);
        @(negedge clk); alloc_valid_i = 0; issue_ready_i = 1; #1;
        check("R4 oldest ready valid", issue_valid_o, 1);
        check("R4 oldest ready tag", issue_tag_o, 0);
        check("R4 operand a", issue_a_o, 10);
        check("R4 operand b", issue_b_o, 20);
        check("R4 opcode", issue_op_o, 1);
        @(negedge clk); #1;
        check("R3 started slot skipped", issue_tag_o, 2);
        @(negedge clk); issue_ready_i = 0; drive_wb(3'd2, 16'd99, 4'd0); #1;
        check("R3 waiting slot held back", issue_valid_o, 0);
        @(negedge clk); drive_wb(3'd0, 16'd55, 4'd0); #1;
        check("R7 younger done waits", retire_valid_o, 0);
        @(negedge clk); wb_valid_i = 0; issue_ready_i = 1; #1;
        check("R7 retire head valid", retire_valid_o, 1);
        check("R7 retire tag", retire_tag_o, 0);
        check("R7 retire data", retire_data_o, 55);
        check("R7 retire dst_en", retire_dst_en_o, 1);
        check("R7 retire dst", retire_dst_o, 3);
        check("R5 woken slot offered", issue_valid_o, 1);
        check("R5 woken tag", issue_tag_o, 1);
        check("R5 woken value", issue_a_o, 55);
        check("R5 other operand", issue_b_o, 7);
        @(negedge clk); issue_ready_i = 0; drive_wb(3'd1, 16'd77, 4'd0); #1;
        check("R7 head not done", retire_valid_o, 0);
        @(negedge clk); wb_valid_i = 0; #1;
        check("R7 retire second", retire_tag_o, 1);
        check("R7 retire second data", retire_data_o, 77);
        check("R7 retire second dst", retire_dst_o, 4);
        @(negedge clk); #1;
        check("R7 retire third", retire_valid_o, 1);
        check("R7 third tag", retire_tag_o, 2);
        check("R7 third data", retire_data_o, 99);
        check("R7 third dst_en", retire_dst_en_o, 0);
        @(negedge clk); #1;
        check("R7 drained", retire_valid_o, 0);
        check("R2 tail position", alloc_tag_o, 3);
    endtask

    task automatic t_bypass();
        @(negedge clk); drive_alloc(4'h1, 1, 16'd1, 1, 16'd2, 1, 5'd1);
        @(negedge clk); alloc_valid_i = 0; issue_ready_i = 1; #1;
        check("R4 single ready", issue_tag_o, 3);
        @(negedge clk);
        issue_ready_i = 0;
        drive_alloc(4'h2, 0, 16'd3, 1, 16'd4, 1, 5'd2);
        drive_wb(3'd3, 16'h0123, 4'd0);
        @(negedge clk); alloc_valid_i = 0; wb_valid_i = 0; issue_ready_i = 1; #1;
        check("R6 captured entry offered", issue_valid_o, 1);
        check("R6 captured tag", issue_tag_o, 4);
        check("R6 captured value", issue_a_o, 16'h0123);
        check("R7 producer retires", retire_tag_o, 3);
        check("R7 producer data", retire_data_o, 16'h0123);
        @(negedge clk); issue_ready_i = 0; drive_wb(3'd4, 16'h0044, 4'd0);
        @(negedge clk); wb_valid_i = 0; #1;
        check("R7 retire slot4", retire_valid_o, 1);
        check("R8 non-store no strobe", retire_store_o, 0);
    endtask

    task automatic t_store();
        @(negedge clk); drive_alloc(4'hF, 1, 16'd8, 1, 16'd9, 0, 5'd0);
        @(negedge clk); alloc_valid_i = 0; #1;
        check("R8 store waiting", retire_store_o, 0);
        drive_wb(3'd5, 16'h0055, 4'd0);
        #1;
        check("R8 store at completion", retire_store_o, 0);
        @(negedge clk); wb_valid_i = 0; #1;
        check("R8 store retire valid", retire_valid_o, 1);
        check("R8 store strobe", retire_store_o, 1);
        check("R8 store tag", retire_tag_o, 5);
    endtask

    task automatic t_late_exc();
        @(negedge clk); drive_alloc(4'h1, 1, 16'd1, 1, 16'd1, 1, 5'd6);
        @(negedge clk); drive_alloc(4'h1, 1, 16'd1, 1, 16'd1, 1, 5'd7);
        @(negedge clk); alloc_valid_i = 0; drive_wb(3'd7, 16'd0, 4'd2);
        @(negedge clk); drive_wb(3'd6, 16'd6, 4'd0); #1;
        check("R9 younger cause hidden", exc_valid_o, 0);
        @(negedge clk); wb_valid_i = 0; #1;
        check("R9 older retires first", retire_tag_o, 6);
        check("R9 older retire valid", retire_valid_o, 1);
        @(negedge clk); #1;
        check("R9 late exc valid", exc_valid_o, 1);
        check("R9 late exc cause", exc_cause_o, 2);
        check("R9 late exc tag", exc_tag_o, 7);
        @(negedge clk); #1;
        check("R9 tail equals head", alloc_tag_o, 7);
        check("R9 exc cleared", exc_valid_o, 0);
        check("R9 nothing retires", retire_valid_o, 0);
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_fill_flush();
        t_order();
        t_bypass();
        t_store();
        t_late_exc();
        repeat (2) @(negedge clk);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule